// File: doc/BRIEF.md
# Channel-Scalable Logic-Analyzer Command Parser

This block sits behind a UART receiver and turns its byte stream into complete logic-analyzer commands. A byte with bit 7 clear is a one-byte command. A byte with bit 7 set opens a long command. A long command is followed by a payload that is always one byte for every eight channels. With the default 64 channels, a long command is therefore 9 bytes, and with 32 channels it is 5 bytes. The payload is assembled least-significant byte first. When the last byte lands, the opcode and the assembled word are presented together with a one-clock strobe.

Two opcodes are also decoded in place. 0xC0 loads a per-channel trigger mask, and 0xC1 loads a per-channel trigger level. Together they give each channel a trigger condition of low, high or don't care to the sampling logic. A serial host link delivers bytes with long and irregular idle gaps between them. If a command stalls longer than a parameterised number of clocks, the partial command is dropped silently, so a confused host can always resynchronise.

Top module: `sump_cmd_parser`

## Requirements
- R1: While `rst` is high at a clock edge, `cmd_valid`, `cmd_opcode`, `cmd_payload`, `trig_mask` and `trig_value` all become zero and the parser returns to waiting for an opcode.
- R2: When the parser is waiting for an opcode, a byte with bit 7 clear is a complete command. In the next cycle `cmd_valid` is 1, `cmd_opcode` equals that byte and `cmd_payload` is zero.
- R3: A byte with bit 7 set opens a long command of exactly 1 + CHANNELS/8 bytes. `cmd_valid` pulses once, in the cycle after the last byte, and never earlier.
- R4: Payload byte k (counting from 0) lands in `cmd_payload[8k+7:8k]`, so the first payload byte carries channels 7..0.
- R5: A completed long command with opcode 0xC0 copies its payload into `trig_mask`, and one with opcode 0xC1 copies it into `trig_value`. No other command changes either register.
- R6: `cmd_valid` is high for one clock for each completed command. `cmd_opcode` and `cmd_payload` hold their value in every cycle without a strobe.
- R7: Payload bytes of 0x00 are consumed like any other byte. A command whose upper bytes are all zero still completes only after its full length.
- R8: While a long command is open, TIMEOUT_CLKS consecutive clocks without `rx_valid` discard it without a strobe. The next byte is then taken as a new opcode.
- R9: A payload byte that arrives after exactly TIMEOUT_CLKS-1 empty clocks is still accepted as part of the open command.
- R10: Raising `rst` in the middle of a long command discards it. The first byte after reset is taken as an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | Qualifies `rx_byte` for one clock |
| rx_byte | input | 8 | Received byte |
| cmd_valid | output | 1 | One-clock strobe, command complete |
| cmd_opcode | output | 8 | Opcode of the last completed command |
| cmd_payload | output | CHANNELS | Assembled payload of the last completed command |
| trig_mask | output | CHANNELS | Per-channel trigger mask, loaded by 0xC0 |
| trig_value | output | CHANNELS | Per-channel trigger level, loaded by 0xC1 |

## Verification
Two events can fall in the same clock: the inter-byte timer reaching its limit and a payload byte arriving. The bench provokes the boundary from both sides. In one case it waits exactly TIMEOUT_CLKS-1 empty clocks and then sends the rest of a 0xC1 command, and it judges that the strobe appears and `trig_value` loads. In the other case it waits TIMEOUT_CLKS clocks and sends a short command, and it judges that exactly one strobe carries the short opcode while `trig_mask` is unchanged. Reset arriving during an open command is judged the same way: the partial command is lost, and the following byte acts as an opcode.

// File: rtl/sump_cmd_parser.sv
module sump_cmd_parser #(
  parameter int CHANNELS     = 64,
  parameter int TIMEOUT_CLKS = 1000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rx_valid,
  input  logic [7:0]          rx_byte,
  output logic                cmd_valid,
  output logic [7:0]          cmd_opcode,
  output logic [CHANNELS-1:0] cmd_payload,
  output logic [CHANNELS-1:0] trig_mask,
  output logic [CHANNELS-1:0] trig_value
);

  localparam int PAY_BYTES = CHANNELS / 8;
  localparam int CNT_W     = $clog2(PAY_BYTES + 1);
  localparam int GAP_W     = $clog2(TIMEOUT_CLKS + 1);
  localparam logic [7:0] OP_MASK  = 8'hC0;
  localparam logic [7:0] OP_VALUE = 8'hC1;
  localparam logic [CNT_W-1:0] LAST_IDX  = CNT_W'(PAY_BYTES - 1);
  localparam logic [GAP_W-1:0] GAP_LIMIT = GAP_W'(TIMEOUT_CLKS - 1);

  logic                busy;
  logic [7:0]          op_q;
  logic [CNT_W-1:0]    idx;
  logic [GAP_W-1:0]    gap;
  logic [CHANNELS-1:0] shreg;

  wire take_op  = rx_valid && !busy;
  wire take_pay = rx_valid && busy;
  wire last_pay = take_pay && (idx == LAST_IDX);
  wire expire   = busy && !rx_valid && (gap == GAP_LIMIT);
  wire [CHANNELS-1:0] next_word = {rx_byte, shreg[CHANNELS-1:8]};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      op_q        <= '0;
      idx         <= '0;
      gap         <= '0;
      shreg       <= '0;
      cmd_valid   <= 1'b0;
      cmd_opcode  <= '0;
      cmd_payload <= '0;
      trig_mask   <= '0;
      trig_value  <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (take_op) begin
        op_q <= rx_byte;
        idx  <= '0;
        gap  <= '0;
        if (rx_byte[7]) begin
          busy <= 1'b1;
        end else begin
          cmd_valid   <= 1'b1;
          cmd_opcode  <= rx_byte;
          cmd_payload <= '0;
        end
      end else if (take_pay) begin
        shreg <= next_word;
        idx   <= idx + 1'b1;
        gap   <= '0;
        if (last_pay) begin
          busy        <= 1'b0;
          cmd_valid   <= 1'b1;
          cmd_opcode  <= op_q;
          cmd_payload <= next_word;
          if (op_q == OP_MASK)  trig_mask  <= next_word;
          if (op_q == OP_VALUE) trig_value <= next_word;
        end
      end else if (expire) begin
        busy <= 1'b0;
        gap  <= '0;
      end else if (busy) begin
        gap <= gap + 1'b1;
      end
    end
  end

  logic r_seen = 1'b0;
  logic past_ok = 1'b0;
  always_ff @(posedge clk) begin
    if (rst) r_seen <= 1'b1;
    past_ok <= r_seen;
  end

  // R2
  short_strobe_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (take_op && !rx_byte[7]) |=> (cmd_valid && cmd_opcode == $past(rx_byte) && cmd_payload == '0));

  // R6
  hold_outputs_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    !cmd_valid |-> ($stable(cmd_opcode) && $stable(cmd_payload)));

  // R5
  mask_src_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    !$stable(trig_mask) |-> (cmd_valid && cmd_opcode == OP_MASK));

  // R5
  value_src_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    !$stable(trig_value) |-> (cmd_valid && cmd_opcode == OP_VALUE));

  // R3
  long_end_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (cmd_valid && cmd_opcode[7]) |-> ($past(rx_valid) && $past(busy) && !busy));

  // R8
  gap_bound_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    busy |-> (gap <= GAP_LIMIT));

endmodule

// File: tb/sim_sump_cmd_parser.sv
`timescale 1ns/1ps
module sim_sump_cmd_parser;
  localparam int CH = 64;
  localparam int TO = 40;
  localparam int NV = 7;
  localparam logic [7:0]  VOP  [0:NV-1] = '{8'h00, 8'hC0, 8'hC1, 8'h11, 8'h81, 8'hC1, 8'hC0};
  localparam logic [63:0] VPAY [0:NV-1] = '{64'h0, 64'h0123_4567_89AB_CDEF, 64'h0000_0000_0000_00A5,
                                            64'h0, 64'hFFFF_0000_FFFF_0000, 64'h8000_0000_0000_0001, 64'h0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic cmd_valid;
  logic [7:0] cmd_opcode;
  logic [CH-1:0] cmd_payload, trig_mask, trig_value;

  int total = 0;
  int bad = 0;
  int nstrobe = 0;
  logic [CH-1:0] exp_mask = '0;
  logic [CH-1:0] exp_value = '0;

  always #5 clk = ~clk;

  sump_cmd_parser #(.CHANNELS(CH), .TIMEOUT_CLKS(TO)) u0 (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode), .cmd_payload(cmd_payload),
    .trig_mask(trig_mask), .trig_value(trig_value));

  always @(posedge clk) begin
    #2;
    if (cmd_valid) nstrobe++;
  end

  task automatic chk(string req, logic [CH-1:0] act, logic [CH-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(logic [7:0] b);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
    rx_byte  = '0;
  endtask

  task automatic send_cmd(logic [7:0] op, logic [63:0] pay, int gap);
    int s0;
    s0 = nstrobe;
    send_byte(op);
    if (op[7]) begin
      for (int b = 0; b < CH/8; b++) begin
        repeat (gap + (b % 3)) @(negedge clk);
        if (b == CH/8 - 1) chk("R3 no early strobe", CH'(nstrobe - s0), '0);
        send_byte(pay[8*b +: 8]);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 cmd_valid", CH'(cmd_valid), '0);
    chk("R1 opcode", CH'(cmd_opcode), '0);
    chk("R1 mask", trig_mask, '0);
    chk("R1 value", trig_value, '0);

    for (int i = 0; i < NV; i++) begin
      s0 = nstrobe;
      send_cmd(VOP[i], VPAY[i], i % 4);
      if (VOP[i] == 8'hC0) exp_mask = VPAY[i];
      if (VOP[i] == 8'hC1) exp_value = VPAY[i];
      // R2 R3 R4 strobe and contents
      chk("R3 strobe", CH'(cmd_valid), 1);
      chk("R2 opcode", CH'(cmd_opcode), CH'(VOP[i]));
      chk("R4 payload", cmd_payload, VOP[i][7] ? VPAY[i] : '0);
      @(negedge clk);
      // R6 single strobe, held outputs
      chk("R6 strobe drop", CH'(cmd_valid), '0);
      chk("R6 one strobe", CH'(nstrobe - s0), 1);
      repeat (3) @(negedge clk);
      chk("R6 opcode held", CH'(cmd_opcode), CH'(VOP[i]));
      chk("R5 mask", trig_mask, exp_mask);
      chk("R5 value", trig_value, exp_value);
    end

    // R7 zero padding consumed: 0xC1 with only low byte nonzero
    s0 = nstrobe;
    send_cmd(8'hC1, 64'h0000_0000_0000_003C, 1);
    exp_value = 64'h3C;
    chk("R7 strobe count", CH'(nstrobe - s0), 1);
    chk("R7 value", trig_value, exp_value);
    @(negedge clk);

    // R2 back-to-back short commands
    s0 = nstrobe;
    send_byte(8'h01);
    chk("R2 first short", CH'(cmd_opcode), 8'h01);
    send_byte(8'h02);
    chk("R2 second short", CH'(cmd_opcode), 8'h02);
    chk("R2 two strobes", CH'(nstrobe - s0), 2);
    @(negedge clk);

    // R8 timeout: open 0xC0, stall TO clocks, then a short command
    s0 = nstrobe;
    send_byte(8'hC0);
    send_byte(8'hAA); send_byte(8'hBB); send_byte(8'hCC);
    repeat (TO) @(negedge clk);
    chk("R8 no strobe on timeout", CH'(nstrobe - s0), '0);
    send_byte(8'h05);
    chk("R8 fresh opcode", CH'(cmd_opcode), 8'h05);
    chk("R8 strobe", CH'(cmd_valid), 1);
    chk("R8 mask kept", trig_mask, exp_mask);
    @(negedge clk);

    // R9 byte on the last tolerated clock
    s0 = nstrobe;
    send_byte(8'hC1);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
    repeat (TO - 1) @(negedge clk);
    send_byte(8'h44); send_byte(8'h55); send_byte(8'h66); send_byte(8'h77); send_byte(8'h88);
    exp_value = 64'h8877_6655_4433_2211;
    chk("R9 strobe", CH'(nstrobe - s0), 1);
    chk("R9 opcode", CH'(cmd_opcode), 8'hC1);
    chk("R9 value", trig_value, exp_value);
    @(negedge clk);

    // R10 reset mid-command
    send_byte(8'hC0);
    send_byte(8'h99); send_byte(8'h98); send_byte(8'h97); send_byte(8'h96);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R10 mask cleared", trig_mask, '0);
    chk("R10 value cleared", trig_value, '0);
    s0 = nstrobe;
    send_byte(8'h07);
    chk("R10 opcode after reset", CH'(cmd_opcode), 8'h07);
    chk("R10 strobe", CH'(nstrobe - s0), 1);
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule